// File: doc/BRIEF.md
# Interrupt Level and Threshold State

This block keeps the machine-mode interrupt-level state of one hart running under a level-based interrupt controller. It holds the active interrupt level, the previous level saved at trap entry, and a software threshold, and it presents the effective level (the larger of the active level and the threshold) to the interrupt-taking logic. Level 0 stands for ordinary execution outside any handler.

The pipeline tells the block when a trap is taken and when a return instruction retires. On an interrupt trap the current level is saved and the taken level becomes active. On an exception trap the level is saved and the active level is left alone. On a return the saved level is restored. If the return drops to a less privileged mode, the threshold also falls to its minimum. A mode input selects between the level-based scheme and the classic scheme. Leaving the level-based scheme clears the saved level.

Three CSR views are served through a select and a write strobe: the read-only status view, the threshold, and the level-related part of the cause register. The cause view also shows the previous-privilege and previous-enable bits mirrored from the status register, which is owned elsewhere.

Top module: `ilvl_state`

## Requirements
- R1: After reset the active level, the saved level and the threshold are all 0, so the effective level output is 0.
- R2: `eff_lvl_o` always equals the larger of the active level and the threshold, and is never below the active level.
- R3: A write with `csr_sel_i`=1 (threshold) stores `csr_wdata_i[7:0]`. A threshold read returns the stored value in bits 7:0, with bits 31:8 reading zero.
- R4: With `clic_mode_i`=1, `trap_take_i` with `trap_intr_i`=1 copies the active level into the saved level and makes `trap_lvl_i` the active level from the next cycle. With `trap_intr_i`=0, the level is saved and the active level stays unchanged.
- R5: With `clic_mode_i`=1, `ret_i` restores the active level from the saved level on the next cycle. If `ret_lower_i`=1 as well, the threshold becomes 0. Otherwise the threshold is kept.
- R6: A cause read (`csr_sel_i`=2) in the level-based mode returns `status_mpp_i` in bits 29:28, `status_mpie_i` in bit 27, the saved level in bits 23:16, and zero elsewhere. In the classic mode (`clic_mode_i`=0) the whole read is zero.
- R7: When `clic_mode_i` is 1 in one cycle and 0 in the next, the saved level is cleared at that edge.
- R8: A status read (`csr_sel_i`=0) returns the active level in bits 31:24 and zero elsewhere, in either mode. Writes to the status view have no effect.
- R9: When events coincide, the return-to-lower threshold reset wins over a threshold write in the same cycle. A trap entry or return wins over a cause write in the same cycle. A trap entry wins over a return in the same cycle.
- R10: With `clic_mode_i`=0, trap entry and return leave the active and saved levels unchanged.
- R11: A cause write in the level-based mode loads the saved level from `csr_wdata_i[23:16]`. In the classic mode a cause write is ignored.
- R12: `csr_sel_i`=3 reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clic_mode_i | input | 1 | 1 selects the level-based interrupt scheme |
| trap_take_i | input | 1 | Trap entry strobe |
| trap_intr_i | input | 1 | Trap is an interrupt (1) or an exception (0) |
| trap_lvl_i | input | 8 | Level of the interrupt being taken |
| ret_i | input | 1 | Machine return strobe |
| ret_lower_i | input | 1 | The return goes to a less privileged mode |
| status_mpp_i | input | 2 | Previous-privilege bits from the status register |
| status_mpie_i | input | 1 | Previous-enable bit from the status register |
| csr_sel_i | input | 2 | View select: 0 status, 1 threshold, 2 cause, 3 none |
| csr_we_i | input | 1 | Write strobe for the selected view |
| csr_wdata_i | input | 32 | Write data |
| csr_rdata_o | output | 32 | Read data of the selected view |
| eff_lvl_o | output | 8 | Effective interrupt level |

## Verification
Two pairs of functions can land in the same cycle. The first is a return to a lower privilege together with a threshold write. The second is a trap entry together with a cause write. The bench provokes each pair by raising both strobes before one rising edge. It then judges the outcome through the threshold and cause reads afterwards: the threshold must read zero, and the saved level must hold the pre-entry active level rather than the written value.

// File: rtl/ilvl_pkg.sv
package ilvl_pkg;
  localparam int unsigned DATA_W = 32;

  typedef enum logic [1:0] {
    SEL_STATUS = 2'd0,
    SEL_THRESH = 2'd1,
    SEL_CAUSE  = 2'd2,
    SEL_NONE   = 2'd3
  } csr_sel_e;

  localparam int unsigned CAUSE_MPP_LSB  = 28;
  localparam int unsigned CAUSE_MPIE_BIT = 27;
  localparam int unsigned CAUSE_PIL_LSB  = 16;
endpackage

// File: rtl/ilvl_max.sv
module ilvl_max #(
  parameter int unsigned LVL_W = 8
) (
  input  logic [LVL_W-1:0] a_i,
  input  logic [LVL_W-1:0] b_i,
  output logic [LVL_W-1:0] max_o
);
  always_comb begin
    max_o = (a_i >= b_i) ? a_i : b_i;
  end
endmodule

// File: rtl/ilvl_thresh.sv
module ilvl_thresh #(
  parameter int unsigned LVL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [LVL_W-1:0] wr_val,
  input  logic             clr_en,
  output logic [LVL_W-1:0] th_o
);
  localparam logic [LVL_W-1:0] TH_MIN = '0;

  logic [LVL_W-1:0] th_q, th_d;
  logic             th_en;

  always_comb begin
    th_en = clr_en | wr_en;
    th_d  = clr_en ? TH_MIN : wr_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     th_q <= TH_MIN;
    else if (th_en) th_q <= th_d;
  end

  assign th_o = th_q;

  AST_RET_THRESH_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> (th_o == TH_MIN)); // R5
  AST_THRESH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_en && !wr_en) |=> $stable(th_o)); // R3
endmodule

// File: rtl/ilvl_track.sv
module ilvl_track #(
  parameter int unsigned LVL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             entry_en,
  input  logic             entry_intr,
  input  logic [LVL_W-1:0] entry_lvl,
  input  logic             ret_en,
  input  logic             pil_wr_en,
  input  logic [LVL_W-1:0] pil_wr_val,
  input  logic             pil_clr,
  output logic [LVL_W-1:0] il_o,
  output logic [LVL_W-1:0] pil_o
);
  logic [LVL_W-1:0] il_q, il_d, pil_q, pil_d;
  logic             il_en, pil_en;

  always_comb begin
    il_d   = il_q;
    pil_d  = pil_q;
    il_en  = 1'b0;
    pil_en = 1'b0;
    if (pil_clr) begin
      pil_d  = '0;
      pil_en = 1'b1;
    end else if (entry_en) begin
      pil_d  = il_q;
      pil_en = 1'b1;
      if (entry_intr) begin
        il_d  = entry_lvl;
        il_en = 1'b1;
      end
    end else if (ret_en) begin
      il_d  = pil_q;
      il_en = 1'b1;
    end else if (pil_wr_en) begin
      pil_d  = pil_wr_val;
      pil_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     il_q <= '0;
    else if (il_en) il_q <= il_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pil_q <= '0;
    else if (pil_en) pil_q <= pil_d;
  end

  assign il_o  = il_q;
  assign pil_o = pil_q;

  AST_ENTRY_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_en && entry_intr && !pil_clr) |=> (il_o == $past(entry_lvl))); // R4
  AST_ENTRY_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_en && !pil_clr) |=> (pil_o == $past(il_o))); // R4
  AST_RET_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_en && !entry_en) |=> (il_o == $past(pil_o))); // R5
endmodule

// File: rtl/ilvl_state.sv
module ilvl_state
  import ilvl_pkg::*;
#(
  parameter int unsigned LVL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clic_mode_i,
  input  logic             trap_take_i,
  input  logic             trap_intr_i,
  input  logic [LVL_W-1:0] trap_lvl_i,
  input  logic             ret_i,
  input  logic             ret_lower_i,
  input  logic [1:0]       status_mpp_i,
  input  logic             status_mpie_i,
  input  logic [1:0]       csr_sel_i,
  input  logic             csr_we_i,
  input  logic [31:0]      csr_wdata_i,
  output logic [31:0]      csr_rdata_o,
  output logic [LVL_W-1:0] eff_lvl_o
);
  localparam int unsigned IL_LSB = DATA_W - LVL_W;

  csr_sel_e         sel;
  logic             mode_q;
  logic             mode_fall;
  logic             entry_en, ret_en, pil_wr_en, th_wr_en, th_clr;
  logic [LVL_W-1:0] il, pil, th;

  assign sel = csr_sel_e'(csr_sel_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= 1'b0;
    else        mode_q <= clic_mode_i;
  end

  always_comb begin
    mode_fall = mode_q & ~clic_mode_i;
    entry_en  = trap_take_i & clic_mode_i;
    ret_en    = ret_i & clic_mode_i;
    pil_wr_en = csr_we_i & (sel == SEL_CAUSE) & clic_mode_i;
    th_wr_en  = csr_we_i & (sel == SEL_THRESH);
    th_clr    = ret_en & ret_lower_i;
  end

  ilvl_track #(.LVL_W(LVL_W)) u_track (
    .clk        (clk),
    .rst_n      (rst_n),
    .entry_en   (entry_en),
    .entry_intr (trap_intr_i),
    .entry_lvl  (trap_lvl_i),
    .ret_en     (ret_en),
    .pil_wr_en  (pil_wr_en),
    .pil_wr_val (csr_wdata_i[CAUSE_PIL_LSB +: LVL_W]),
    .pil_clr    (mode_fall),
    .il_o       (il),
    .pil_o      (pil)
  );

  ilvl_thresh #(.LVL_W(LVL_W)) u_thresh (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (th_wr_en),
    .wr_val (csr_wdata_i[LVL_W-1:0]),
    .clr_en (th_clr),
    .th_o   (th)
  );

  ilvl_max #(.LVL_W(LVL_W)) u_max (
    .a_i   (il),
    .b_i   (th),
    .max_o (eff_lvl_o)
  );

  always_comb begin
    csr_rdata_o = '0;
    unique case (sel)
      SEL_STATUS: csr_rdata_o[IL_LSB +: LVL_W] = il;
      SEL_THRESH: csr_rdata_o[LVL_W-1:0] = th;
      SEL_CAUSE: begin
        if (clic_mode_i) begin
          csr_rdata_o[CAUSE_MPP_LSB +: 2]   = status_mpp_i;
          csr_rdata_o[CAUSE_MPIE_BIT]       = status_mpie_i;
          csr_rdata_o[CAUSE_PIL_LSB +: LVL_W] = pil;
        end
      end
      default: csr_rdata_o = '0;
    endcase
  end

  AST_EFF_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (eff_lvl_o >= il) && (eff_lvl_o >= th)); // R2
  AST_EXIT_PIL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    mode_fall |=> (pil == '0)); // R7
  AST_STATUS_RO: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we_i && sel == SEL_STATUS && !entry_en && !ret_en) |=> $stable(il)); // R8
  AST_CLINT_NO_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    (!clic_mode_i && !mode_q) |=> ($stable(il) && $stable(pil))); // R10
endmodule

// File: tb/tb_ilvl_state.sv
module tb_ilvl_state;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        clic_mode_i, trap_take_i, trap_intr_i, ret_i, ret_lower_i;
  logic [7:0]  trap_lvl_i;
  logic [1:0]  status_mpp_i, csr_sel_i;
  logic        status_mpie_i, csr_we_i;
  logic [31:0] csr_wdata_i, csr_rdata_o;
  logic [7:0]  eff_lvl_o;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  ilvl_state dut (
    .clk(clk), .rst_n(rst_n), .clic_mode_i(clic_mode_i),
    .trap_take_i(trap_take_i), .trap_intr_i(trap_intr_i), .trap_lvl_i(trap_lvl_i),
    .ret_i(ret_i), .ret_lower_i(ret_lower_i),
    .status_mpp_i(status_mpp_i), .status_mpie_i(status_mpie_i),
    .csr_sel_i(csr_sel_i), .csr_we_i(csr_we_i), .csr_wdata_i(csr_wdata_i),
    .csr_rdata_o(csr_rdata_o), .eff_lvl_o(eff_lvl_o)
  );

  // {trap level, threshold, expected effective level}
  localparam logic [23:0] VEC [6] = '{
    {8'd5,   8'd0,   8'd5},
    {8'd3,   8'd7,   8'd7},
    {8'd200, 8'd199, 8'd200},
    {8'd9,   8'd9,   8'd9},
    {8'd1,   8'd255, 8'd255},
    {8'd255, 8'd0,   8'd255}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    trap_take_i = 1'b0; ret_i = 1'b0; ret_lower_i = 1'b0; csr_we_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [31:0] v);
    csr_sel_i = s;
    #1;
    v = csr_rdata_o;
  endtask

  task automatic csr_write(input logic [1:0] s, input logic [31:0] d);
    csr_sel_i = s; csr_we_i = 1'b1; csr_wdata_i = d;
    tick();
  endtask

  task automatic enter(input logic intr, input logic [7:0] l);
    trap_take_i = 1'b1; trap_intr_i = intr; trap_lvl_i = l;
    tick();
  endtask

  task automatic leave(input logic lower);
    ret_i = 1'b1; ret_lower_i = lower;
    tick();
  endtask

  initial begin
    #150000;
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; clic_mode_i = 1'b1; trap_take_i = 0; trap_intr_i = 0; trap_lvl_i = 0;
    ret_i = 0; ret_lower_i = 0; status_mpp_i = 2'b11; status_mpie_i = 1'b1;
    csr_sel_i = 0; csr_we_i = 0; csr_wdata_i = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1;
    // R1 reset state
    check("R1 eff", {24'd0, eff_lvl_o}, 32'd0);
    rd(2'd0, v); check("R1 status", v, 32'd0);
    rd(2'd1, v); check("R1 thresh", v, 32'd0);
    rd(2'd2, v); check("R1 cause", v, 32'h3800_0000);

    // R2 vector walk
    foreach (VEC[i]) begin
      csr_write(2'd1, {24'd0, VEC[i][15:8]});
      enter(1'b1, VEC[i][23:16]);
      check("R2 eff", {24'd0, eff_lvl_o}, {24'd0, VEC[i][7:0]});
      rd(2'd0, v); check("R4 status level", v, {VEC[i][23:16], 24'd0});
      leave(1'b0);
      rd(2'd0, v); check("R5 restore", v, 32'd0);
      rd(2'd1, v); check("R5 thresh kept", v, {24'd0, VEC[i][15:8]});
    end

    // R3 upper bits dropped
    csr_write(2'd1, 32'hFFFF_FF12);
    rd(2'd1, v); check("R3 thresh", v, 32'h0000_0012);

    // R4 nesting and exception entry
    enter(1'b1, 8'd5);
    enter(1'b1, 8'd9);
    rd(2'd2, v); check("R4 pil nested", v, 32'h3805_0000);
    rd(2'd0, v); check("R4 il nested", v, 32'h0900_0000);
    enter(1'b0, 8'd40);
    rd(2'd0, v); check("R4 exc il kept", v, 32'h0900_0000);
    rd(2'd2, v); check("R4 exc pil", v, 32'h3809_0000);

    // R6 mirror fields
    status_mpp_i = 2'b01; status_mpie_i = 1'b0;
    rd(2'd2, v); check("R6 mirror", v, 32'h1009_0000);

    // R5 return to lower resets threshold
    leave(1'b1);
    rd(2'd1, v); check("R5 thresh min", v, 32'd0);
    rd(2'd0, v); check("R5 il restored", v, 32'h0900_0000);

    // R9 return-lower vs threshold write
    csr_write(2'd1, 32'd30);
    csr_sel_i = 2'd1; csr_we_i = 1'b1; csr_wdata_i = 32'd44;
    ret_i = 1'b1; ret_lower_i = 1'b1;
    tick();
    rd(2'd1, v); check("R9 thresh write loses", v, 32'd0);

    // R9 trap entry vs cause write: il now 9 (pil 9 restored)
    csr_sel_i = 2'd2; csr_we_i = 1'b1; csr_wdata_i = 32'h0077_0000;
    trap_take_i = 1'b1; trap_intr_i = 1'b1; trap_lvl_i = 8'd12;
    tick();
    rd(2'd2, v); check("R9 cause write loses", v, 32'h1009_0000);

    // R11 cause write alone
    csr_write(2'd2, 32'h0033_0000);
    rd(2'd2, v); check("R11 pil write", v, 32'h1033_0000);

    // R8 status write ignored
    csr_write(2'd0, 32'hAB00_0000);
    rd(2'd0, v); check("R8 status ro", v, 32'h0C00_0000);

    // R7 leaving level mode clears pil; R6 classic read zero
    clic_mode_i = 1'b0;
    tick();
    rd(2'd2, v); check("R6 classic cause", v, 32'd0);
    rd(2'd0, v); check("R8 status classic", v, 32'h0C00_0000);
    // R10 traps ignored in classic mode
    enter(1'b1, 8'd99);
    leave(1'b0);
    rd(2'd0, v); check("R10 il unchanged", v, 32'h0C00_0000);
    // R11 cause write ignored in classic mode
    csr_write(2'd2, 32'h0055_0000);
    clic_mode_i = 1'b1;
    tick();
    rd(2'd2, v); check("R7 pil zeroed", v, 32'h1000_0000);

    // R12 unused select
    rd(2'd3, v); check("R12 none", v, 32'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule